// File: doc/BRIEF.md
# Level-Sensitive Interrupt Register Front End

This block is the register side of a level-sensitive interrupt controller. It serves up to four banks of 32 request lines. It keeps the state that software programs: a mask for each line, software-raised requests, a routing bit that sends a line to the normal path or the fast path, and a 6-bit priority for each line. It also keeps a few global registers: an identification value, a reset-done flag, an auto-idle flag, a 2-bit idle field and a global disable flag. A simple 32-bit read/write port gives access to all of them.

The block forms a pending bit for each line. A hardware request that becomes active sets the bit. Software can also raise it through a sticky set register. When a hardware request drops, the bit falls back to the line's software bit. An external arbiter receives two masked pending vectors, one for each path, together with every line's priority. It chooses the winner and returns the winning line numbers, which software reads through two code registers. Writes to the control register send the arbiter one-cycle re-arm pulses and set or clear the global disable.

Top module: `lvlirq_regfe`

## Requirements
- R1: After reset every mask bit is 1. The software bits, pending bits, routing bits, priorities, auto-idle flag, idle field and global disable are all 0. Both re-arm pulses are low and `rdata_o` is 0.
- R2: A read returns its data on `rdata_o` the cycle after `rd_en`. `rdata_o` is 0 in any cycle after a cycle without `rd_en`, and reads change no state. Offset 0x000 reads 0x21 and offset 0x014 reads 1.
- R3: Writing offset 0x010 stores wdata bit 0 as the auto-idle flag, which reads back in bit 0. Writing wdata bit 1 as 1 returns all state to the R1 values on the next cycle.
- R4: Writing offset 0x048 stores wdata bit 2 as the global disable, which reads back in bit 2 and drives `gmask_o`. Wdata bit 0 gives a one-cycle pulse on `rearm_irq_o` the cycle after the write, and wdata bit 1 does the same on `rearm_fiq_o`.
- R5: Offset 0x050 stores and returns a 2-bit idle field in bits [1:0]. Offsets 0x040 and 0x044 return `irq_code_i` and `fiq_code_i`, zero-extended.
- R6: Bank b (b < NUM_BANKS) has its registers at 0x080 + 0x20·b, so address bits [6:5] select the bank. Offset +0x00 reads the latched hardware inputs and +0x04 reads or writes the whole mask. +0x10 reads the software bits, and a write to it is a software set.
- R7: A write to +0x08 clears the written mask bits and a write to +0x0C sets them. Both of these registers, and +0x14, read as 0.
- R8: A software set at +0x10 ORs the value into both the software bits and the pending bits. A software clear at +0x14 clears the written software bits and makes the bank's pending bits equal to the remaining software bits ANDed with the latched inputs.
- R9: Each input is sampled once per clock. A 0-to-1 change sets the line's pending bit. A 1-to-0 change sets the pending bit to the line's software bit. Both take effect on the edge that samples the change.
- R10: `pend_irq_o` is pending AND NOT mask AND NOT routing bit, and `pend_fiq_o` is pending AND NOT mask AND routing bit. Both outputs are all-zero while the global disable is set. The bank reads +0x18 and +0x1C return the same values without the global gating.
- R11: The line register for line l of bank b is at 0x100 + 0x80·b + 4·l. Wdata bits [7:2] are the priority and bit 0 is the routing bit (1 = fast path). Both read back in those positions with bit 1 always 0. `prio_o[6·(32·b+l) +: 6]` carries the priority.
- R12: Writes to read-only or unmapped offsets change nothing. Reads of unmapped offsets return 0. Unmapped offsets include addresses whose bits [1:0] are non-zero and banks at or above NUM_BANKS.

Line numbers run from 0 to 32·NUM_BANKS−1. Line n of the port vectors is line n mod 32 of bank n/32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after rd_en |
| irq_i | input | 32·NUM_BANKS | Level request inputs, active high |
| irq_code_i | input | CODE_W | Winning normal-path line from the arbiter |
| fiq_code_i | input | CODE_W | Winning fast-path line from the arbiter |
| pend_irq_o | output | 32·NUM_BANKS | Masked pending lines routed to the normal path |
| pend_fiq_o | output | 32·NUM_BANKS | Masked pending lines routed to the fast path |
| prio_o | output | 192·NUM_BANKS | Packed 6-bit priority for each line |
| gmask_o | output | 1 | Global disable flag |
| rearm_irq_o | output | 1 | One-cycle re-arm pulse for the normal path |
| rearm_fiq_o | output | 1 | One-cycle re-arm pulse for the fast path |

## Verification
Every result appears exactly one clock after its cause, because the read data, the pending state, the control flags and the re-arm pulses all live in flops that load on the edge that sees the stimulus. The bench therefore applies a stimulus on a falling edge and advances its reference model on the next rising edge. On the falling edge after that it compares `rdata_o`, both pending vectors, `prio_o`, `gmask_o` and the re-arm pulses against the model. Directed checks with constant expected values sit on top of this per-cycle comparison, at the same sampling point.

// File: rtl/lvlirq_pkg.sv
package lvlirq_pkg;

    localparam int LINES  = 32;
    localparam int PRIO_W = 6;

    // global register byte offsets
    localparam logic [11:0] A_REV   = 12'h000;
    localparam logic [11:0] A_SYSC  = 12'h010;
    localparam logic [11:0] A_STAT  = 12'h014;
    localparam logic [11:0] A_ICODE = 12'h040;
    localparam logic [11:0] A_FCODE = 12'h044;
    localparam logic [11:0] A_CTRL  = 12'h048;
    localparam logic [11:0] A_IDLE  = 12'h050;

    localparam logic [31:0] REV_VAL = 32'h0000_0021;

    // word index inside a bank window
    localparam logic [2:0] B_IN   = 3'd0;
    localparam logic [2:0] B_MASK = 3'd1;
    localparam logic [2:0] B_MCLR = 3'd2;
    localparam logic [2:0] B_MSET = 3'd3;
    localparam logic [2:0] B_SWS  = 3'd4;
    localparam logic [2:0] B_SWC  = 3'd5;
    localparam logic [2:0] B_PIRQ = 3'd6;
    localparam logic [2:0] B_PFIQ = 3'd7;

    typedef struct packed {
        logic [LINES-1:0]             inp;
        logic [LINES-1:0]             mask;
        logic [LINES-1:0]             swi;
        logic [LINES-1:0]             pend;
        logic [LINES-1:0]             fiq;
        logic [LINES-1:0][PRIO_W-1:0] prio;
    } bank_st_t;

    localparam bank_st_t BANK_RST = '{inp: '0, mask: '1, swi: '0,
                                      pend: '0, fiq: '0, prio: '0};

    typedef struct packed {
        logic       autoidle;
        logic [1:0] idle;
        logic       gmask;
        logic       rearm_irq;
        logic       rearm_fiq;
    } glob_st_t;

    localparam glob_st_t GLOB_RST = '{autoidle: 1'b0, idle: 2'b00, gmask: 1'b0,
                                      rearm_irq: 1'b0, rearm_fiq: 1'b0};

endpackage

// File: rtl/lvlirq_bank.sv
module lvlirq_bank
    import lvlirq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         soft_rst,
    input  logic [LINES-1:0]             irq_i,
    input  logic                         wr_mask,
    input  logic                         wr_mclr,
    input  logic                         wr_mset,
    input  logic                         wr_sset,
    input  logic                         wr_sclr,
    input  logic                         wr_line,
    input  logic [4:0]                   line_idx,
    input  logic [31:0]                  wdata,
    output logic [LINES-1:0]             in_o,
    output logic [LINES-1:0]             mask_o,
    output logic [LINES-1:0]             swi_o,
    output logic [LINES-1:0]             pend_o,
    output logic [LINES-1:0]             fiq_o,
    output logic [LINES-1:0][PRIO_W-1:0] prio_o
);

    bank_st_t         st_d, st_q;
    logic [LINES-1:0] rise, fall;

    assign rise = irq_i & ~st_q.inp;
    assign fall = ~irq_i & st_q.inp;

    always_comb begin
        st_d = st_q;
        if (wr_mask) st_d.mask = wdata;
        if (wr_mclr) st_d.mask = st_q.mask & ~wdata;
        if (wr_mset) st_d.mask = st_q.mask | wdata;
        if (wr_sset) begin
            st_d.swi  = st_q.swi | wdata;
            st_d.pend = st_q.pend | wdata;
        end
        if (wr_sclr) begin
            st_d.swi  = st_q.swi & ~wdata;
            st_d.pend = st_d.swi & st_q.inp;
        end
        if (wr_line) begin
            st_d.prio[line_idx] = wdata[7:2];
            st_d.fiq[line_idx]  = wdata[0];
        end
        // level tracking: a new request sets, a dropped request falls back to software
        st_d.pend = ((st_d.pend | rise) & ~fall) | (fall & st_d.swi);
        st_d.inp  = irq_i;
        if (soft_rst) st_d = BANK_RST;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BANK_RST;
        else        st_q <= st_d;
    end

    assign in_o   = st_q.inp;
    assign mask_o = st_q.mask;
    assign swi_o  = st_q.swi;
    assign pend_o = st_q.pend;
    assign fiq_o  = st_q.fiq;
    assign prio_o = st_q.prio;

endmodule

// File: rtl/lvlirq_glob.sv
module lvlirq_glob
    import lvlirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       wr_sysc,
    input  logic       wr_ctrl,
    input  logic       wr_idle,
    input  logic [2:0] wbits,
    output logic       autoidle_o,
    output logic [1:0] idle_o,
    output logic       gmask_o,
    output logic       rearm_irq_o,
    output logic       rearm_fiq_o
);

    glob_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rearm_irq = 1'b0;
        st_d.rearm_fiq = 1'b0;
        if (wr_sysc) st_d.autoidle = wbits[0];
        if (wr_idle) st_d.idle = wbits[1:0];
        if (wr_ctrl) begin
            st_d.gmask     = wbits[2];
            st_d.rearm_irq = wbits[0];
            st_d.rearm_fiq = wbits[1];
        end
        if (soft_rst) st_d = GLOB_RST;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= GLOB_RST;
        else        st_q <= st_d;
    end

    assign autoidle_o  = st_q.autoidle;
    assign idle_o      = st_q.idle;
    assign gmask_o     = st_q.gmask;
    assign rearm_irq_o = st_q.rearm_irq;
    assign rearm_fiq_o = st_q.rearm_fiq;

endmodule

// File: rtl/lvlirq_regfe.sv
module lvlirq_regfe
    import lvlirq_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int NL        = NUM_BANKS * LINES,
    localparam int CODE_W    = $clog2(NL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [11:0]          addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata_o,
    input  logic [NL-1:0]        irq_i,
    input  logic [CODE_W-1:0]    irq_code_i,
    input  logic [CODE_W-1:0]    fiq_code_i,
    output logic [NL-1:0]        pend_irq_o,
    output logic [NL-1:0]        pend_fiq_o,
    output logic [NL*PRIO_W-1:0] prio_o,
    output logic                 gmask_o,
    output logic                 rearm_irq_o,
    output logic                 rearm_fiq_o
);

    localparam logic [4:0] NB5 = 5'(NUM_BANKS);

    // address decode
    logic       aligned, in_bank, in_line, soft_rst;
    logic [4:0] blk, lblk;
    logic [1:0] bsel, lb;
    logic [2:0] breg;
    logic [4:0] lidx;

    assign aligned  = (addr[1:0] == 2'b00);
    assign blk      = addr[11:7];
    assign bsel     = addr[6:5];
    assign breg     = addr[4:2];
    assign lidx     = addr[6:2];
    assign lblk     = blk - 5'd2;
    assign lb       = lblk[1:0];
    assign in_bank  = aligned && (blk == 5'd1) && ({3'b000, bsel} < NB5);
    assign in_line  = aligned && (blk >= 5'd2) && (lblk < NB5);
    assign soft_rst = wr_en && aligned && (addr == A_SYSC) && wdata[1];

    // bank state
    logic [LINES-1:0]             b_in   [NUM_BANKS];
    logic [LINES-1:0]             b_mask [NUM_BANKS];
    logic [LINES-1:0]             b_swi  [NUM_BANKS];
    logic [LINES-1:0]             b_pend [NUM_BANKS];
    logic [LINES-1:0]             b_fiq  [NUM_BANKS];
    logic [LINES-1:0][PRIO_W-1:0] b_prio [NUM_BANKS];

    logic       g_autoidle, g_gmask;
    logic [1:0] g_idle;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bwr, lwr;
        assign bwr = wr_en && in_bank && (bsel == 2'(b));
        assign lwr = wr_en && in_line && (lblk == 5'(b));

        lvlirq_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .irq_i    (irq_i[b*LINES +: LINES]),
            .wr_mask  (bwr && (breg == B_MASK)),
            .wr_mclr  (bwr && (breg == B_MCLR)),
            .wr_mset  (bwr && (breg == B_MSET)),
            .wr_sset  (bwr && (breg == B_SWS)),
            .wr_sclr  (bwr && (breg == B_SWC)),
            .wr_line  (lwr),
            .line_idx (lidx),
            .wdata    (wdata),
            .in_o     (b_in[b]),
            .mask_o   (b_mask[b]),
            .swi_o    (b_swi[b]),
            .pend_o   (b_pend[b]),
            .fiq_o    (b_fiq[b]),
            .prio_o   (b_prio[b])
        );

        assign pend_irq_o[b*LINES +: LINES] = g_gmask ? '0 : (b_pend[b] & ~b_mask[b] & ~b_fiq[b]);
        assign pend_fiq_o[b*LINES +: LINES] = g_gmask ? '0 : (b_pend[b] & ~b_mask[b] & b_fiq[b]);
        assign prio_o[b*LINES*PRIO_W +: LINES*PRIO_W] = b_prio[b];
    end

    lvlirq_glob u_glob (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .wr_sysc     (wr_en && aligned && (addr == A_SYSC)),
        .wr_ctrl     (wr_en && aligned && (addr == A_CTRL)),
        .wr_idle     (wr_en && aligned && (addr == A_IDLE)),
        .wbits       (wdata[2:0]),
        .autoidle_o  (g_autoidle),
        .idle_o      (g_idle),
        .gmask_o     (g_gmask),
        .rearm_irq_o (rearm_irq_o),
        .rearm_fiq_o (rearm_fiq_o)
    );

    assign gmask_o = g_gmask;

    // read path
    logic [31:0] rd_val, rdata_d, rdata_q;

    always_comb begin
        rd_val = '0;
        if (in_bank) begin
            unique case (breg)
                B_IN:   rd_val = b_in[bsel];
                B_MASK: rd_val = b_mask[bsel];
                B_SWS:  rd_val = b_swi[bsel];
                B_PIRQ: rd_val = b_pend[bsel] & ~b_mask[bsel] & ~b_fiq[bsel];
                B_PFIQ: rd_val = b_pend[bsel] & ~b_mask[bsel] & b_fiq[bsel];
                B_MCLR, B_MSET, B_SWC: rd_val = '0;
            endcase
        end else if (in_line) begin
            rd_val = {24'b0, b_prio[lb][lidx], 1'b0, b_fiq[lb][lidx]};
        end else if (aligned) begin
            case (addr)
                A_REV:   rd_val = REV_VAL;
                A_SYSC:  rd_val = {31'b0, g_autoidle};
                A_STAT:  rd_val = 32'd1;
                A_ICODE: rd_val = 32'(irq_code_i);
                A_FCODE: rd_val = 32'(fiq_code_i);
                A_CTRL:  rd_val = {29'b0, g_gmask, 2'b00};
                A_IDLE:  rd_val = {30'b0, g_idle};
                default: rd_val = '0;
            endcase
        end
    end

    assign rdata_d = rd_en ? rd_val : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/lvlirq_regfe_chk.sv
module lvlirq_regfe_chk #(
    parameter  int NUM_BANKS = 4,
    localparam int NL        = NUM_BANKS * 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [11:0]   addr,
    input logic [31:0]   wdata,
    input logic [31:0]   rdata_o,
    input logic [NL-1:0] pend_irq_o,
    input logic [NL-1:0] pend_fiq_o,
    input logic          gmask_o,
    input logic          rearm_irq_o,
    input logic          rearm_fiq_o
);

    logic ctrl_wr, sysc_wr;
    assign ctrl_wr = wr_en && (addr == 12'h048);
    assign sysc_wr = wr_en && (addr == 12'h010);

    p_rev_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 12'h000) |=> (rdata_o == 32'h21));

    p_stat_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 12'h014) |=> (rdata_o == 32'd1));

    p_no_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata_o == 32'd0));

    p_soft_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sysc_wr && wdata[1]) |=> (!gmask_o && pend_irq_o == '0 && pend_fiq_o == '0));

    p_gmask_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (gmask_o == $past(wdata[2])));

    p_rearm_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[0]) |=> rearm_irq_o);

    p_rearm_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && wdata[0]) |=> !rearm_irq_o);

    p_rearm_fiq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && wdata[1]) |=> !rearm_fiq_o);

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_o |-> (pend_irq_o == '0 && pend_fiq_o == '0));

    p_disjoint_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_irq_o & pend_fiq_o) == '0));

endmodule

bind lvlirq_regfe lvlirq_regfe_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata_o     (rdata_o),
    .pend_irq_o  (pend_irq_o),
    .pend_fiq_o  (pend_fiq_o),
    .gmask_o     (gmask_o),
    .rearm_irq_o (rearm_irq_o),
    .rearm_fiq_o (rearm_fiq_o)
);

// File: tb/lvlirq_regfe_tb.sv
module lvlirq_regfe_tb;

    localparam int NB = 4;
    localparam int NL = NB * 32;
    localparam int CW = $clog2(NL);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata_o;
    logic [NL-1:0]   irq_i = '0;
    logic [CW-1:0]   irq_code_i = '0, fiq_code_i = '0;
    logic [NL-1:0]   pend_irq_o, pend_fiq_o;
    logic [NL*6-1:0] prio_o;
    logic            gmask_o, rearm_irq_o, rearm_fiq_o;

    always #2 clk = ~clk;   // 250 MHz

    lvlirq_regfe #(.NUM_BANKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata_o(rdata_o), .irq_i(irq_i), .irq_code_i(irq_code_i),
        .fiq_code_i(fiq_code_i), .pend_irq_o(pend_irq_o), .pend_fiq_o(pend_fiq_o),
        .prio_o(prio_o), .gmask_o(gmask_o), .rearm_irq_o(rearm_irq_o),
        .rearm_fiq_o(rearm_fiq_o)
    );

    int    checks = 0, failures = 0;
    bit    finished = 1'b0;
    string cur_req = "R2";

    // reference model state
    logic [31:0] m_in[NB], m_pend[NB], m_mask[NB], m_sw[NB], m_fiq[NB];
    logic [5:0]  m_prio[NB][32];
    logic        m_gm, m_ai, m_ri, m_rf;
    logic [1:0]  m_idle;
    logic [31:0] m_rd;

    task automatic check(string req, logic [767:0] act, logic [767:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int b = 0; b < NB; b++) begin
            m_in[b] = '0; m_pend[b] = '0; m_mask[b] = '1; m_sw[b] = '0; m_fiq[b] = '0;
            for (int l = 0; l < 32; l++) m_prio[b][l] = '0;
        end
        m_gm = 0; m_ai = 0; m_idle = 0; m_ri = 0; m_rf = 0;
    endtask

    function automatic logic [31:0] m_read(int a);
        int b, r, l;
        if (a % 4 != 0) return 0;
        if (a >= 128 && a < 256) begin
            b = (a - 128) / 32; r = (a % 32) / 4;
            if (b >= NB) return 0;
            case (r)
                0: return m_in[b];
                1: return m_mask[b];
                4: return m_sw[b];
                6: return m_pend[b] & ~m_mask[b] & ~m_fiq[b];
                7: return m_pend[b] & ~m_mask[b] & m_fiq[b];
                default: return 0;
            endcase
        end
        if (a >= 256 && a < 256 + 128 * NB) begin
            b = (a - 256) / 128; l = (a % 128) / 4;
            return (32'(m_prio[b][l]) << 2) | 32'(m_fiq[b][l]);
        end
        case (a)
            0:  return 32'h21;
            16: return 32'(m_ai);
            20: return 1;
            64: return 32'(irq_code_i);
            68: return 32'(fiq_code_i);
            72: return 32'(m_gm) << 2;
            80: return 32'(m_idle);
            default: return 0;
        endcase
    endfunction

    task automatic m_write(int a, logic [31:0] v, output bit sr);
        int b, r, l;
        sr = 0;
        if (a % 4 != 0) return;
        if (a == 16) begin m_ai = v[0]; sr = v[1]; end
        else if (a == 72) begin m_gm = v[2]; m_ri = v[0]; m_rf = v[1]; end
        else if (a == 80) m_idle = v[1:0];
        else if (a >= 128 && a < 256) begin
            b = (a - 128) / 32; r = (a % 32) / 4;
            if (b < NB) case (r)
                1: m_mask[b] = v;
                2: m_mask[b] = m_mask[b] & ~v;
                3: m_mask[b] = m_mask[b] | v;
                4: begin m_sw[b] = m_sw[b] | v; m_pend[b] = m_pend[b] | v; end
                5: begin m_sw[b] = m_sw[b] & ~v; m_pend[b] = m_sw[b] & m_in[b]; end
                default: ;
            endcase
        end else if (a >= 256 && a < 256 + 128 * NB) begin
            b = (a - 256) / 128; l = (a % 128) / 4;
            m_prio[b][l] = v[7:2];
            m_fiq[b][l] = v[0];
        end
    endtask

    task automatic m_step();
        logic [31:0] rdv;
        bit sr;
        rdv = rd_en ? m_read(int'(addr)) : 32'd0;
        m_ri = 0; m_rf = 0; sr = 0;
        if (wr_en) m_write(int'(addr), wdata, sr);
        for (int b = 0; b < NB; b++)
            for (int l = 0; l < 32; l++) begin
                if (irq_i[b*32+l] && !m_in[b][l]) m_pend[b][l] = 1'b1;
                else if (!irq_i[b*32+l] && m_in[b][l]) m_pend[b][l] = m_sw[b][l];
                m_in[b][l] = irq_i[b*32+l];
            end
        if (sr) m_reset();
        m_rd = rdv;
    endtask

    task automatic compare_all();
        logic [NL-1:0]   ei, ef;
        logic [NL*6-1:0] ep;
        for (int b = 0; b < NB; b++) begin
            ei[b*32 +: 32] = m_gm ? 32'd0 : (m_pend[b] & ~m_mask[b] & ~m_fiq[b]);
            ef[b*32 +: 32] = m_gm ? 32'd0 : (m_pend[b] & ~m_mask[b] & m_fiq[b]);
            for (int l = 0; l < 32; l++) ep[(b*32+l)*6 +: 6] = m_prio[b][l];
        end
        check(cur_req, 768'(rdata_o), 768'(m_rd));
        check("R10 irq", 768'(pend_irq_o), 768'(ei));
        check("R10 fiq", 768'(pend_fiq_o), 768'(ef));
        check("R11 prio", 768'(prio_o), 768'(ep));
        check("R4 gmask", 768'(gmask_o), 768'(m_gm));
        check("R4 rearm", 768'({rearm_irq_o, rearm_fiq_o}), 768'({m_ri, m_rf}));
    endtask

    task automatic cycle();
        @(posedge clk);
        if (!rst_n) begin m_reset(); m_rd = '0; end
        else m_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] v);
        wr_en = 1; addr = a; wdata = v;
        cycle();
        wr_en = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        rd_en = 1; addr = a;
        cycle();
        v = rdata_o;
        rd_en = 0;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        m_reset(); m_rd = '0;
        @(negedge clk);
        cur_req = "R1";
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        // R1 reset state
        check("R1 rdata", 768'(rdata_o), 768'(0));
        check("R1 pend", 768'(pend_irq_o | pend_fiq_o), 768'(0));
        rd(12'h0A4, v); check("R1 mask", 768'(v), 768'(32'hFFFF_FFFF));
        rd(12'h104, v); check("R1 line", 768'(v), 768'(0));
        // R2 fixed registers and latency
        cur_req = "R2";
        rd(12'h000, v); check("R2 rev", 768'(v), 768'(32'h21));
        rd(12'h014, v); check("R2 status", 768'(v), 768'(1));
        cycle(); check("R2 idle rdata", 768'(rdata_o), 768'(0));
        // R6 bank addressing and mask write
        cur_req = "R6";
        wr(12'h0C4, 32'h0000_FFFF);
        rd(12'h0C4, v); check("R6 bank2 mask", 768'(v), 768'(32'h0000_FFFF));
        rd(12'h0A4, v); check("R6 bank1 untouched", 768'(v), 768'(32'hFFFF_FFFF));
        // R7 mask clear / set
        cur_req = "R7";
        wr(12'h0C8, 32'h0000_000F);
        rd(12'h0C4, v); check("R7 clear", 768'(v), 768'(32'h0000_FFF0));
        wr(12'h0CC, 32'h0000_0001);
        rd(12'h0C4, v); check("R7 set", 768'(v), 768'(32'h0000_FFF1));
        rd(12'h0C8, v); check("R7 clr reads 0", 768'(v), 768'(0));
        // R9 level inputs
        cur_req = "R9";
        wr(12'h084, 32'h0);
        irq_i[3] = 1; cycle();
        check("R9 rise", 768'(pend_irq_o[3]), 768'(1));
        rd(12'h080, v); check("R9 raw", 768'(v), 768'(32'h8));
        irq_i[3] = 0; cycle();
        check("R9 fall", 768'(pend_irq_o[3]), 768'(0));
        // R8 software set / clear
        cur_req = "R8";
        wr(12'h090, 32'h30);
        check("R8 set pend", 768'(pend_irq_o[5:4]), 768'(2'b11));
        rd(12'h090, v); check("R8 sw bits", 768'(v), 768'(32'h30));
        irq_i[4] = 1; cycle(); irq_i[4] = 0; cycle();
        check("R8 R9 sticky after fall", 768'(pend_irq_o[4]), 768'(1));
        wr(12'h094, 32'h10);
        rd(12'h098, v); check("R8 clear recompute", 768'(v), 768'(0));
        rd(12'h090, v); check("R8 sw remain", 768'(v), 768'(32'h20));
        // R11 line registers
        cur_req = "R11";
        wr(12'h19C, 32'hFF);
        rd(12'h19C, v); check("R11 readback", 768'(v), 768'(32'hFD));
        check("R11 prio_o", 768'(prio_o[39*6 +: 6]), 768'(63));
        // R10 routing and global gate
        cur_req = "R10";
        wr(12'h0A4, 32'h0);
        wr(12'h0B0, 32'h80);
        check("R10 fiq path", 768'({pend_fiq_o[39], pend_irq_o[39]}), 768'(2'b10));
        wr(12'h048, 32'h4);
        check("R10 gated", 768'(pend_fiq_o), 768'(0));
        rd(12'h0BC, v); check("R10 ungated read", 768'(v), 768'(32'h80));
        rd(12'h048, v); check("R4 ctrl readback", 768'(v), 768'(4));
        wr(12'h048, 32'h0);
        check("R10 ungate", 768'(pend_fiq_o[39]), 768'(1));
        // R4 re-arm pulses
        cur_req = "R4";
        wr(12'h048, 32'h1);
        check("R4 irq pulse", 768'({rearm_irq_o, rearm_fiq_o}), 768'(2'b10));
        cycle(); check("R4 pulse ends", 768'(rearm_irq_o), 768'(0));
        wr(12'h048, 32'h2);
        check("R4 fiq pulse", 768'({rearm_irq_o, rearm_fiq_o}), 768'(2'b01));
        // R5 idle and codes
        cur_req = "R5";
        wr(12'h050, 32'hFF);
        rd(12'h050, v); check("R5 idle", 768'(v), 768'(3));
        irq_code_i = 7'h55; fiq_code_i = 7'h2A;
        rd(12'h040, v); check("R5 irq code", 768'(v), 768'(32'h55));
        rd(12'h044, v); check("R5 fiq code", 768'(v), 768'(32'h2A));
        // R12 ignored writes and unmapped reads
        cur_req = "R12";
        wr(12'h000, 32'hFFFF);
        rd(12'h000, v); check("R12 ro rev", 768'(v), 768'(32'h21));
        wr(12'h0B8, 32'hFFFF_FFFF);
        rd(12'h0B0, v); check("R12 ro pending", 768'(v), 768'(32'h80));
        wr(12'h300, 32'hFF);
        rd(12'h100, v); check("R12 no alias", 768'(v), 768'(0));
        rd(12'h300, v); check("R12 unmapped", 768'(v), 768'(0));
        wr(12'h0C6, 32'h0);
        rd(12'h0C4, v); check("R12 unaligned", 768'(v), 768'(32'h0000_FFF1));
        // R3 sysconfig and soft reset
        cur_req = "R3";
        wr(12'h010, 32'h1);
        rd(12'h010, v); check("R3 autoidle", 768'(v), 768'(1));
        wr(12'h010, 32'h2);
        check("R3 soft reset pend", 768'(pend_fiq_o | pend_irq_o), 768'(0));
        rd(12'h010, v); check("R3 autoidle cleared", 768'(v), 768'(0));
        rd(12'h0C4, v); check("R3 mask reset", 768'(v), 768'(32'hFFFF_FFFF));
        rd(12'h19C, v); check("R3 line reset", 768'(v), 768'(0));
        // mixed traffic against the model
        cur_req = "R6 mixed";
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [11:0] a;
            op = int'($urandom % 16);
            if ($urandom % 3 == 0) irq_i[$urandom % NL] ^= 1'b1;
            irq_code_i = CW'($urandom); fiq_code_i = CW'($urandom);
            case ($urandom % 4)
                0: a = 12'h080 + 12'($urandom % 4) * 12'h20 + 12'($urandom % 8) * 12'h4;
                1: a = 12'h100 + 12'($urandom % 4) * 12'h80 + 12'($urandom % 32) * 12'h4;
                2: a = 12'h040 + 12'($urandom % 6) * 12'h4;
                default: a = 12'($urandom % 4096);
            endcase
            if (op < 6) begin
                wr_en = 1; addr = a; wdata = $urandom;
                if (a == 12'h010 && ($urandom % 8 != 0)) wdata[1] = 1'b0;
                if (a == 12'h048) wdata[2] = ($urandom % 4 == 0);
            end else if (op < 12) begin
                rd_en = 1; addr = a;
            end
            cycle();
            wr_en = 0; rd_en = 0;
        end
        finish_up();
    end

endmodule